// File: doc/BRIEF.md
# Row Activate Hammer Monitor

This block watches the command stream that a memory controller sends to one bank and keeps a running count of row activations inside a counting window. The window is twice the refresh window, so the block counts refresh-window ticks and clears itself on every second tick. Counts are held for a small number of recently active rows in a fully associative table. Exact per-row counters for the whole array are not kept. When a row is new and the table is full, the entry with the lowest count is evicted, and the newcomer takes that count plus one. An estimate made this way can only be too high, never too low.

A row is flagged as an aggressor in two cases. The first is when its own count reaches the programmable limit. The second is when its count, added to the count of the row two positions away, reaches the limit: the row between them is a victim disturbed by both of its neighbours. The block then raises a request that carries the aggressor row and its bank. The controller can answer by issuing a full set of refreshes or by running a targeted refresh of the neighbouring rows. The request stays up until the controller pulses mitigation-done. That pulse also drops the tracked counts of the aggressor and of both of its neighbours.

Top module: `row_hammer_mon`

## Requirements
- R1: After a synchronous active-low reset, `hm_req`, `win_reset` and `agg_row` are 0, and no row holds a count.
- R2: An accepted activate (`cmd_valid`=1, `cmd_type`=3'd1, `cmd_bank`=MON_BANK) that brings its row's count to `cfg_mac` or above sets `hm_req` on the next clock edge. On that same edge, `agg_row` takes the activated row and `agg_bank` takes the bank.
- R3: An accepted activate to row r also sets `hm_req` when r's new count plus the count of row r-2, or plus the count of row r+2, reaches `cfg_mac`. A neighbour row that would fall outside the row range counts as 0.
- R4: While `hm_req` is high, it stays high and `agg_row`/`agg_bank` stay unchanged until `mit_done` is seen. Activates that arrive during this time are still counted, but they raise no new request.
- R5: `mit_done` while `hm_req` is high clears `hm_req` on the next edge. It also removes the tracked counts of `agg_row`, `agg_row`-1 and `agg_row`+1. Any later activate to one of those rows starts again from 1.
- R6: `win_expire` marks one refresh window. Every second pulse pulses `win_reset` high for one cycle, on the next edge, and clears every tracked count.
- R7: Commands with another `cmd_type`, activates to another bank, and any command with `cmd_valid`=0 leave all counts unchanged.
- R8: A new row takes a free table slot with count 1 when one exists. When the table is full, the row replaces the lowest-count entry (lowest slot index on a tie) and starts at that entry's count plus one.
- R9: In a single cycle, a window clear takes priority over mitigation, and mitigation takes priority over an activate. An activate that arrives in a cycle with a window clear or a mitigation is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_type | input | 3 | Command code; 3'd1 is activate |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_row | input | ROW_W | Row addressed by the command |
| win_expire | input | 1 | One-cycle pulse at the end of each refresh window |
| cfg_mac | input | CNT_W | Maximum activate count |
| mit_done | input | 1 | One-cycle pulse: mitigation of the pending aggressor is finished |
| hm_req | output | 1 | Mitigation request pending |
| agg_row | output | ROW_W | Aggressor row of the pending request |
| agg_bank | output | BANK_W | Bank of the pending request |
| win_reset | output | 1 | One-cycle pulse: the counting window restarted |

## Verification
Every result is registered once. A request, its row and bank, and its removal by mitigation-done all appear on the clock edge that samples the activate or the pulse. The same holds for the window-reset pulse after the second window tick. The bench drives each cycle's inputs on the falling edge and updates its reference table at that moment. It compares all four outputs 2 ns after the next rising edge, so each comparison sees exactly one cycle of effect. Directed sequences check the exact activate at which a single-row, a paired-victim or an inherited count crosses the limit, together with the same-cycle priority cases.

// File: rtl/rhm_pkg.sv
// Package: shared command encoding for the row hammer monitor.
// Assumes the controller presents at most one command per cycle.
package rhm_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;
endpackage

// File: rtl/rhm_window.sv
// Module: rhm_window
// Counts refresh-window ticks and flags the tick that ends a counting
// window of WIN_MULT refresh windows. Assumes ticks are single-cycle pulses.
module rhm_window #(
    parameter int WIN_MULT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic wrap
);
    localparam int CW = (WIN_MULT > 1) ? $clog2(WIN_MULT) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_MULT - 1);

    logic [CW-1:0] tick_cnt;

    // The window ends on the tick that finds the counter at its last value.
    assign wrap = tick && (tick_cnt == LAST);

    // Advance the tick counter, restarting at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (wrap)
            tick_cnt <= '0;
        else if (tick)
            tick_cnt <= tick_cnt + 1'b1;
    end
endmodule

// File: rtl/rhm_table.sv
// Module: rhm_table
// Fully associative table of tracked rows and activate counts. For each
// accepted activate it reports the row's updated count and the counts of
// the rows two positions below and above (zero when untracked), then
// writes the entry. A new row takes a free slot first, otherwise the
// lowest-count slot, whose count it inherits plus one. Assumes at most
// one of clr_all / mit_en / act_en matters per cycle, in that priority.
module rhm_table #(
    parameter int ENTRIES = 8,
    parameter int ROW_W   = 16,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             mit_en,
    input  logic [ROW_W-1:0] mit_row,
    input  logic             act_en,
    input  logic [ROW_W-1:0] act_row,
    output logic [CNT_W-1:0] new_cnt,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hi_cnt
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             v_q [ENTRIES];
    logic [ROW_W-1:0] r_q [ENTRIES];
    logic [CNT_W-1:0] c_q [ENTRIES];

    logic [ENTRIES-1:0] m_self, m_lo, m_hi, m_mit;
    logic               lo_ok, hi_ok;
    logic [ROW_W-1:0]   lo_row, hi_row;

    assign lo_ok  = (act_row >= ROW_W'(2));
    assign hi_ok  = (act_row <= ROW_MAX - ROW_W'(2));
    assign lo_row = act_row - ROW_W'(2);
    assign hi_row = act_row + ROW_W'(2);

    // Per-entry tag comparators for the lookup and mitigation rows.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign m_self[i] = v_q[i] && (r_q[i] == act_row);
        assign m_lo[i]   = v_q[i] && lo_ok && (r_q[i] == lo_row);
        assign m_hi[i]   = v_q[i] && hi_ok && (r_q[i] == hi_row);
        assign m_mit[i]  = v_q[i] && ((r_q[i] == mit_row) ||
                           ((mit_row != '0) && (r_q[i] == mit_row - 1'b1)) ||
                           ((mit_row != ROW_MAX) && (r_q[i] == mit_row + 1'b1)));
    end

    logic             hit, free;
    logic [IDX_W-1:0] hit_idx, free_idx, min_idx, tgt_idx;
    logic [CNT_W-1:0] hit_cnt, min_cnt;

    // Reduce comparator results to hit, neighbour counts, free and victim slot.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        hit_cnt  = '0;
        lo_cnt   = '0;
        hi_cnt   = '0;
        free     = 1'b0;
        free_idx = '0;
        min_idx  = '0;
        min_cnt  = CNT_MAX;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_self[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
                hit_cnt = c_q[i];
            end
            if (m_lo[i]) lo_cnt = c_q[i];
            if (m_hi[i]) hi_cnt = c_q[i];
            if (!v_q[i] && !free) begin
                free     = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (v_q[i] && (c_q[i] < min_cnt)) begin
                min_cnt = c_q[i];
                min_idx = IDX_W'(i);
            end
        end
    end

    // Pick the slot to write and the count it will hold, saturating.
    always_comb begin
        if (hit) begin
            tgt_idx = hit_idx;
            new_cnt = (hit_cnt == CNT_MAX) ? CNT_MAX : hit_cnt + 1'b1;
        end else if (free) begin
            tgt_idx = free_idx;
            new_cnt = CNT_W'(1);
        end else begin
            tgt_idx = min_idx;
            new_cnt = (min_cnt == CNT_MAX) ? CNT_MAX : min_cnt + 1'b1;
        end
    end

    // Table state update: window clear, mitigation removal or activate write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                v_q[i] <= 1'b0;
                r_q[i] <= '0;
                c_q[i] <= '0;
            end
        end else if (clr_all) begin
            for (int i = 0; i < ENTRIES; i++) v_q[i] <= 1'b0;
        end else if (mit_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (m_mit[i]) v_q[i] <= 1'b0;
        end else if (act_en) begin
            v_q[tgt_idx] <= 1'b1;
            r_q[tgt_idx] <= act_row;
            c_q[tgt_idx] <= new_cnt;
        end
    end
endmodule

// File: rtl/row_hammer_mon.sv
// Module: row_hammer_mon (top)
// Monitors activates to bank MON_BANK, tracks per-row counts over a window
// of WIN_MULT refresh windows, and raises a held request naming the
// aggressor row when a row, or a victim's pair of neighbours, reaches
// cfg_mac. Assumes cfg_mac is stable while activates are counted.
module row_hammer_mon #(
    parameter int ROW_W    = 16,
    parameter int BANK_W   = 3,
    parameter int CNT_W    = 8,
    parameter int ENTRIES  = 8,
    parameter int WIN_MULT = 2,
    parameter int MON_BANK = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_type,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic              win_expire,
    input  logic [CNT_W-1:0]  cfg_mac,
    input  logic              mit_done,
    output logic              hm_req,
    output logic [ROW_W-1:0]  agg_row,
    output logic [BANK_W-1:0] agg_bank,
    output logic              win_reset
);
    import rhm_pkg::*;

    logic             win_clr, mit_en, act_en, trigger;
    logic [CNT_W-1:0] new_cnt, lo_cnt, hi_cnt;
    logic [CNT_W:0]   sum_lo, sum_hi;

    rhm_window #(.WIN_MULT(WIN_MULT)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (win_expire),
        .wrap  (win_clr)
    );

    // Qualify mitigation and activates; clear beats mitigation beats activate.
    assign mit_en = mit_done && hm_req;
    assign act_en = cmd_valid && (cmd_type == CMD_ACT) &&
                    (cmd_bank == BANK_W'(MON_BANK)) && !win_clr && !mit_en;

    rhm_table #(.ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (win_clr),
        .mit_en  (mit_en),
        .mit_row (agg_row),
        .act_en  (act_en),
        .act_row (cmd_row),
        .new_cnt (new_cnt),
        .lo_cnt  (lo_cnt),
        .hi_cnt  (hi_cnt)
    );

    // Threshold test on the row itself and on both victim pairs.
    assign sum_lo  = {1'b0, new_cnt} + {1'b0, lo_cnt};
    assign sum_hi  = {1'b0, new_cnt} + {1'b0, hi_cnt};
    assign trigger = act_en && !hm_req &&
                     ((new_cnt >= cfg_mac) ||
                      (sum_lo >= {1'b0, cfg_mac}) ||
                      (sum_hi >= {1'b0, cfg_mac}));

    // Request register: set on a trigger, held until mitigation-done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hm_req   <= 1'b0;
            agg_row  <= '0;
            agg_bank <= '0;
        end else if (mit_en) begin
            hm_req   <= 1'b0;
        end else if (trigger) begin
            hm_req   <= 1'b1;
            agg_row  <= cmd_row;
            agg_bank <= cmd_bank;
        end
    end

    // One-cycle indication that the counting window restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_reset <= 1'b0;
        else
            win_reset <= win_clr;
    end
endmodule

// File: rtl/rhm_checker.sv
// Module: rhm_checker
// Temporal properties of the row hammer monitor, bound to its top.
module rhm_checker #(
    parameter int ROW_W    = 16,
    parameter int BANK_W   = 3,
    parameter int MON_BANK = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_type,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic              win_expire,
    input logic              mit_done,
    input logic              hm_req,
    input logic [ROW_W-1:0]  agg_row,
    input logic [BANK_W-1:0] agg_bank,
    input logic              win_reset
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hm_req && !mit_done |=> hm_req);

    // R4
    agg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hm_req && !mit_done |=> $stable(agg_row) && $stable(agg_bank));

    // R5
    mit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hm_req && mit_done |=> !hm_req);

    // R2
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hm_req) |-> $past(cmd_valid && cmd_type == 3'd1 &&
                                cmd_bank == BANK_W'(MON_BANK)));

    // R2
    req_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hm_req) |-> (agg_row == $past(cmd_row)) &&
                          (agg_bank == BANK_W'(MON_BANK)));

    // R6
    win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_reset |-> $past(win_expire));
endmodule

bind row_hammer_mon rhm_checker #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .MON_BANK(MON_BANK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .win_expire(win_expire),
    .mit_done(mit_done), .hm_req(hm_req), .agg_row(agg_row),
    .agg_bank(agg_bank), .win_reset(win_reset)
);

// File: tb/row_hammer_mon_tb.sv
// Bench: drives commands on the falling edge, updates a reference table at
// the same time, and compares outputs 2 ns after the next rising edge.
module row_hammer_mon_tb;
    localparam int ROW_W = 16, BANK_W = 3, CNT_W = 8, NENT = 8;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              cmd_valid = 1'b0, win_expire = 1'b0, mit_done = 1'b0;
    logic [2:0]        cmd_type = 3'd0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [ROW_W-1:0]  cmd_row = '0;
    logic [CNT_W-1:0]  cfg_mac = 8'd6;
    logic              hm_req, win_reset;
    logic [ROW_W-1:0]  agg_row;
    logic [BANK_W-1:0] agg_bank;

    int checks = 0, failures = 0;

    row_hammer_mon u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .win_expire(win_expire),
        .cfg_mac(cfg_mac), .mit_done(mit_done), .hm_req(hm_req),
        .agg_row(agg_row), .agg_bank(agg_bank), .win_reset(win_reset)
    );

    always #4 clk = ~clk;

    // Reference table and expected outputs.
    bit mv [NENT];
    int mr [NENT];
    int mc [NENT];
    int wcnt = 0;
    bit e_req = 0, e_wr = 0;
    int e_row = 0, e_bank = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(input int x);
        return (x > 255) ? 255 : x;
    endfunction

    // Apply one cycle of stimulus to the reference table.
    task automatic model(input bit v, input int t, input int b, input int row,
                         input bit ex, input bit md);
        bit wrap, mit, act, trig;
        int h, lo, hi, nc, slot;
        wrap = ex && (wcnt == 1);
        if (ex) wcnt = wrap ? 0 : wcnt + 1;
        mit  = md && e_req;
        act  = v && (t == 1) && (b == 0) && !wrap && !mit;
        trig = 0;
        if (act) begin
            h = -1; lo = 0; hi = 0;
            for (int i = 0; i < NENT; i++) begin
                if (mv[i] && mr[i] == row) h = i;
                if (mv[i] && row >= 2 && mr[i] == row - 2) lo = mc[i];
                if (mv[i] && row <= 65533 && mr[i] == row + 2) hi = mc[i];
            end
            if (h >= 0) begin
                slot = h; nc = sat(mc[h] + 1);
            end else begin
                slot = -1;
                for (int i = 0; i < NENT; i++)
                    if (!mv[i] && slot < 0) slot = i;
                if (slot >= 0) nc = 1;
                else begin
                    slot = 0;
                    for (int i = 1; i < NENT; i++)
                        if (mc[i] < mc[slot]) slot = i;
                    nc = sat(mc[slot] + 1);
                end
            end
            mv[slot] = 1; mr[slot] = row; mc[slot] = nc;
            trig = !e_req && (nc >= int'(cfg_mac) || nc + lo >= int'(cfg_mac) ||
                              nc + hi >= int'(cfg_mac));
        end
        if (wrap) begin
            for (int i = 0; i < NENT; i++) mv[i] = 0;
        end else if (mit) begin
            for (int i = 0; i < NENT; i++)
                if (mv[i] && (mr[i] == e_row || mr[i] == e_row - 1 || mr[i] == e_row + 1))
                    mv[i] = 0;
        end
        e_wr = wrap;
        if (mit) e_req = 0;
        else if (trig) begin
            e_req = 1; e_row = row; e_bank = b;
        end
    endtask

    // One clock of stimulus with a full comparison against the model.
    task automatic cyc(input bit v, input int t, input int b, input int row,
                       input bit ex, input bit md);
        @(negedge clk);
        cmd_valid = v; cmd_type = 3'(t); cmd_bank = BANK_W'(b);
        cmd_row = ROW_W'(row); win_expire = ex; mit_done = md;
        model(v, t, b, row, ex, md);
        @(posedge clk); #2;
        check("R2 req", int'(hm_req), int'(e_req));
        check("R2 agg_row", int'(agg_row), e_row);
        check("R2 agg_bank", int'(agg_bank), e_bank);
        check("R6 win_reset", int'(win_reset), int'(e_wr));
    endtask

    task automatic act(input int row);
        cyc(1, 1, 0, row, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic window_clear();
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin mv[i] = 0; mr[i] = 0; mc[i] = 0; end
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 req", int'(hm_req), 0);
        check("R1 win_reset", int'(win_reset), 0);
        check("R1 agg_row", int'(agg_row), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 single row reaches the limit on its sixth activate
        cfg_mac = 8'd6;
        for (int k = 0; k < 5; k++) act(10);
        check("R2 below limit", int'(hm_req), 0);
        act(10);
        check("R2 at limit", int'(hm_req), 1);
        check("R2 row", int'(agg_row), 10);

        // R4 request held; another row reaching the limit changes nothing
        for (int k = 0; k < 6; k++) act(20);
        check("R4 held", int'(hm_req), 1);
        check("R4 row kept", int'(agg_row), 10);

        // R5 mitigation clears the request and the aggressor's count
        cyc(0, 0, 0, 0, 0, 1);
        check("R5 cleared", int'(hm_req), 0);
        act(10);
        check("R5 count restarted", int'(hm_req), 0);
        act(20);
        check("R5 other row kept", int'(hm_req), 1);
        check("R5 row", int'(agg_row), 20);
        cyc(0, 0, 0, 0, 0, 1);

        // R6 two window ticks clear everything
        cyc(0, 0, 0, 0, 1, 0);
        check("R6 first tick", int'(win_reset), 0);
        cyc(0, 0, 0, 0, 1, 0);
        check("R6 second tick", int'(win_reset), 1);
        idle();
        check("R6 pulse width", int'(win_reset), 0);

        // R3 victim row 5 charged by rows 4 and 6
        for (int k = 0; k < 3; k++) begin act(4); if (k < 2) act(6); end
        check("R3 sum 5", int'(hm_req), 0);
        act(6);
        check("R3 sum 6", int'(hm_req), 1);
        check("R3 row", int'(agg_row), 6);
        cyc(0, 0, 0, 0, 0, 1);
        window_clear();

        // R7 other commands, banks and invalid cycles are not counted
        cfg_mac = 8'd2;
        for (int k = 0; k < 4; k++) cyc(1, 1, 1, 30, 0, 0);
        for (int t = 2; t < 6; t++) cyc(1, t, 0, 30, 0, 0);
        cyc(0, 1, 0, 30, 0, 0);
        act(30);
        check("R7 ignored", int'(hm_req), 0);
        act(30);
        check("R7 second counted", int'(hm_req), 1);
        cyc(0, 0, 0, 0, 0, 1);
        window_clear();

        // R8 full table: newcomer inherits lowest count plus one
        cfg_mac = 8'd20;
        for (int k = 0; k < 8; k++) act(100 + k);
        act(100); act(100);
        for (int k = 0; k < 18; k++) act(200);
        check("R8 at 19", int'(hm_req), 0);
        act(200);
        check("R8 at 20", int'(hm_req), 1);
        check("R8 row", int'(agg_row), 200);
        cyc(0, 0, 0, 0, 0, 1);
        window_clear();

        // R9 priorities: window clear and mitigation swallow an activate
        cfg_mac = 8'd1;
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 50, 1, 0);
        check("R9 clear beats act", int'(hm_req), 0);
        act(50);
        check("R9 act after clear", int'(hm_req), 1);
        cyc(1, 1, 0, 60, 0, 1);
        check("R9 mit clears", int'(hm_req), 0);
        cfg_mac = 8'd2;
        act(60);
        check("R9 act during mit dropped", int'(hm_req), 0);
        window_clear();

        // Random traffic, victim sums checked by the model after every activate
        cfg_mac = 8'd5;
        void'($urandom(32'h5eed));
        for (int n = 0; n < 4000; n++) begin
            int t, b, row;
            bit ex, md;
            t   = ($urandom % 3 == 0) ? int'($urandom % 6) : 1;
            b   = ($urandom % 5 == 0) ? 1 : 0;
            row = int'($urandom % 14);
            ex  = ($urandom % 150 == 0);
            md  = e_req && ($urandom % 4 == 0);
            cyc($urandom % 8 != 0, t, b, row, ex, md);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule